// File: doc/BRIEF.md
# Pipelined Request/Acknowledge Accumulator Server

This block is a clocked server that sits on a four-phase request/acknowledge channel and holds two signed registers. One request updates both of them. The first register, `a_out`, follows a long arithmetic step, (a + 2) * 4 + 4. That step is split into four register stages so that the block can run at a fast clock. The second register, `b_out`, follows a short step, b + 1. Its path is padded with plain delay registers so that both data outputs and the acknowledge change on the same clock edge.

A chain of delayed copies of the request enables each stage in turn. A stage that is not enabled keeps its value. The master raises `req`, waits for `ack`, lowers `req`, and then waits for `ack` to fall before it starts the next transaction. All arithmetic wraps modulo 2^DATA_W.

Top module: `req_ack_pipe_accum`

## Requirements
- R1: While `rst` is high at a rising clock edge, the block sets `a_out` to 1, `b_out` to 0 and `ack` low, and clears every internal request copy.
- R2: `ack` rises on the fourth rising edge after the first edge that samples `req` high. It falls on the fourth rising edge after the first edge that samples `req` low.
- R3: After a complete handshake, `a_out` equals (A + 2) * 4 + 4, where A is its value before the handshake.
- R4: After a complete handshake, `b_out` equals B + 1, where B is its value before the handshake.
- R5: `a_out` and `b_out` take their new values on the same edge on which `ack` rises, and they keep those values while `ack` stays high.
- R6: `a_out` and `b_out` change only in cycles in which `ack` is high, so they hold through idle cycles with `req` and `ack` low.
- R7: Both outputs are DATA_W-bit two's-complement values (16 bits by default), and results wrap modulo 2^DATA_W.
- R8: A reset applied in the middle of a transaction discards that transaction. No `ack` follows it, and the outputs stay at their reset values until a new request arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request from the master, sampled on the clock |
| ack | output | 1 | Registered acknowledge |
| a_out | output | DATA_W | Long-path result register, signed |
| b_out | output | DATA_W | Short-path counter register, signed |

## Verification
The step properties assume a well-behaved master. It raises `req` only while `ack` is low and lowers it in the cycle that follows the rise of `ack`, so the first stage never reloads from an output that has already been updated. It also keeps `req` low while `rst` is high. The bench is that master: it drives `req` on falling edges, clears it right after it sees `ack`, and pulses reset only with `req` low. Across the run it varies the idle gap between transactions and lets the long path wrap around several times.

// File: rtl/hpa_pkg.sv
package hpa_pkg;
   localparam int unsigned STAGES = 4;

   typedef enum logic [0:0] {
      ST_ADD = 1'b0,
      ST_DBL = 1'b1
   } stage_kind_e;

   function automatic stage_kind_e kind_of(int unsigned idx);
      return (idx == 0 || idx == STAGES - 1) ? ST_ADD : ST_DBL;
   endfunction

   function automatic int addend_of(int unsigned idx);
      return (idx == 0) ? 2 : 4;
   endfunction
endpackage

// File: rtl/hpa_req_chain.sv
module hpa_req_chain #(
   parameter int unsigned TAPS = 4
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            req_i,
   output logic [TAPS-1:0] tap_o
);
   for (genvar i = 0; i < TAPS; i++) begin : g_tap
      logic src;
      if (i == 0) begin : g_head
         assign src = req_i;
      end else begin : g_body
         assign src = tap_o[i-1];
      end
      always_ff @(posedge clk) begin
         if (rst) tap_o[i] <= 1'b0;
         else     tap_o[i] <= src;
      end
   end
endmodule

// File: rtl/hpa_stage.sv
module hpa_stage #(
   parameter int unsigned                DATA_W    = 16,
   parameter hpa_pkg::stage_kind_e       KIND      = hpa_pkg::ST_ADD,
   parameter int                         ADDEND    = 2,
   parameter logic signed [DATA_W-1:0]   RESET_VAL = '0,
   parameter bit                         USE_SHIFT = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     en,
   input  logic signed [DATA_W-1:0] d_i,
   output logic signed [DATA_W-1:0] q_o
);
   logic signed [DATA_W-1:0] nxt;

   if (KIND == hpa_pkg::ST_ADD) begin : g_add
      assign nxt = d_i + $signed(DATA_W'(ADDEND));
   end else if (USE_SHIFT) begin : g_shl
      assign nxt = d_i <<< 1;
   end else begin : g_mul
      assign nxt = d_i * $signed(DATA_W'(2));
   end

   always_ff @(posedge clk) begin
      if (rst)     q_o <= RESET_VAL;
      else if (en) q_o <= nxt;
   end
endmodule

// File: rtl/hpa_long_path.sv
module hpa_long_path #(
   parameter int unsigned              DATA_W    = 16,
   parameter logic signed [DATA_W-1:0] A_INIT    = 1,
   parameter bit                       USE_SHIFT = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic [hpa_pkg::STAGES-1:0]    en_i,
   output logic signed [DATA_W-1:0]      a_o
);
   localparam int unsigned NS = hpa_pkg::STAGES;

   logic signed [DATA_W-1:0] stage_q [NS];

   for (genvar i = 0; i < NS; i++) begin : g_stage
      logic signed [DATA_W-1:0] din;
      if (i == 0) begin : g_fb
         assign din = stage_q[NS-1];
      end else begin : g_fw
         assign din = stage_q[i-1];
      end
      hpa_stage #(
         .DATA_W   (DATA_W),
         .KIND     (hpa_pkg::kind_of(i)),
         .ADDEND   (hpa_pkg::addend_of(i)),
         .RESET_VAL((i == NS - 1) ? A_INIT : '0),
         .USE_SHIFT(USE_SHIFT)
      ) u_stage (
         .clk(clk),
         .rst(rst),
         .en (en_i[i]),
         .d_i(din),
         .q_o(stage_q[i])
      );
   end

   assign a_o = stage_q[NS-1];
endmodule

// File: rtl/hpa_short_path.sv
module hpa_short_path #(
   parameter int unsigned              DATA_W = 16,
   parameter logic signed [DATA_W-1:0] B_INIT = 0,
   parameter int                       B_STEP = 1
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     en_i,
   output logic signed [DATA_W-1:0] b_o
);
   localparam int unsigned NBUF = hpa_pkg::STAGES - 1;

   logic signed [DATA_W-1:0] buf_q [NBUF];

   for (genvar i = 0; i < NBUF; i++) begin : g_buf
      logic signed [DATA_W-1:0] src;
      if (i == 0) begin : g_head
         assign src = b_o;
      end else begin : g_body
         assign src = buf_q[i-1];
      end
      always_ff @(posedge clk) begin
         if (rst) buf_q[i] <= B_INIT;
         else     buf_q[i] <= src;
      end
   end

   always_ff @(posedge clk) begin
      if (rst)       b_o <= B_INIT;
      else if (en_i) b_o <= buf_q[NBUF-1] + $signed(DATA_W'(B_STEP));
   end
endmodule

// File: rtl/req_ack_pipe_accum.sv
module req_ack_pipe_accum #(
   parameter int unsigned              DATA_W    = 16,
   parameter logic signed [DATA_W-1:0] A_INIT    = 1,
   parameter logic signed [DATA_W-1:0] B_INIT    = 0,
   parameter bit                       USE_SHIFT = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     req,
   output logic                     ack,
   output logic signed [DATA_W-1:0] a_out,
   output logic signed [DATA_W-1:0] b_out
);
   localparam int unsigned NS = hpa_pkg::STAGES;

   if (DATA_W < 4) begin : g_bad_width
      $error("req_ack_pipe_accum: DATA_W must be at least 4");
   end
   if (NS < 2) begin : g_bad_depth
      $error("req_ack_pipe_accum: stage count must be at least 2");
   end

   logic [NS-1:0] req_tap;
   logic [NS-1:0] stage_en;

   hpa_req_chain #(.TAPS(NS)) u_chain (
      .clk  (clk),
      .rst  (rst),
      .req_i(req),
      .tap_o(req_tap)
   );

   assign stage_en = {req_tap[NS-2:0], req};
   assign ack      = req_tap[NS-1];

   hpa_long_path #(
      .DATA_W   (DATA_W),
      .A_INIT   (A_INIT),
      .USE_SHIFT(USE_SHIFT)
   ) u_long (
      .clk (clk),
      .rst (rst),
      .en_i(stage_en),
      .a_o (a_out)
   );

   hpa_short_path #(
      .DATA_W(DATA_W),
      .B_INIT(B_INIT),
      .B_STEP(1)
   ) u_short (
      .clk (clk),
      .rst (rst),
      .en_i(req_tap[NS-2]),
      .b_o (b_out)
   );
endmodule

// File: rtl/hpa_chk.sv
module hpa_chk #(
   parameter int unsigned DATA_W = 16
) (
   input logic                     clk,
   input logic                     rst,
   input logic                     req,
   input logic                     ack,
   input logic signed [DATA_W-1:0] a_out,
   input logic signed [DATA_W-1:0] b_out
);
   logic [2:0] since_rst;

   always_ff @(posedge clk) begin
      if (rst)                  since_rst <= '0;
      else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
   end

   function automatic logic signed [DATA_W-1:0] long_step(logic signed [DATA_W-1:0] x);
      logic signed [DATA_W-1:0] t;
      t = x + $signed(DATA_W'(2));
      t = t * $signed(DATA_W'(4));
      return t + $signed(DATA_W'(4));
   endfunction

   AST_ACK_LATENCY: assert property (@(posedge clk) disable iff (rst)
      (since_rst >= 3'd4) |-> (ack == $past(req, 4)));                       // R2
   AST_A_STEP: assert property (@(posedge clk) disable iff (rst)
      ((since_rst >= 3'd2) && $rose(ack)) |-> (a_out == long_step($past(a_out)))); // R3
   AST_B_STEP: assert property (@(posedge clk) disable iff (rst)
      ((since_rst >= 3'd2) && $rose(ack)) |-> (b_out == $past(b_out) + $signed(DATA_W'(1)))); // R4
   AST_A_QUIET: assert property (@(posedge clk) disable iff (rst)
      ((since_rst != 3'd0) && !$stable(a_out)) |-> ack);                      // R6
   AST_B_QUIET: assert property (@(posedge clk) disable iff (rst)
      ((since_rst != 3'd0) && !$stable(b_out)) |-> ack);                      // R6
   AST_HOLD_WHILE_ACK: assert property (@(posedge clk) disable iff (rst)
      ((since_rst >= 3'd2) && ack && $past(ack)) |-> ($stable(a_out) && $stable(b_out))); // R5
endmodule

bind req_ack_pipe_accum hpa_chk #(.DATA_W(DATA_W)) u_hpa_chk (
   .clk  (clk),
   .rst  (rst),
   .req  (req),
   .ack  (ack),
   .a_out(a_out),
   .b_out(b_out)
);

// File: tb/test_req_ack_pipe_accum.sv
`timescale 1ns/1ps
module test_req_ack_pipe_accum;
   localparam int unsigned DW = 16;

   logic                 clk = 1'b0;
   logic                 rst = 1'b1;
   logic                 req = 1'b0;
   logic                 ack;
   logic signed [DW-1:0] a_out;
   logic signed [DW-1:0] b_out;

   int n_chk  = 0;
   int n_fail = 0;
   int wraps  = 0;
   bit done   = 1'b0;

   logic signed [DW-1:0] exp_a;
   logic signed [DW-1:0] exp_b;

   always #5 clk = ~clk;

   req_ack_pipe_accum #(.DATA_W(DW)) i_req_ack_pipe_accum (
      .clk  (clk),
      .rst  (rst),
      .req  (req),
      .ack  (ack),
      .a_out(a_out),
      .b_out(b_out)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic handshake(input int gap);
      int n;
      longint wide;
      @(negedge clk);
      req = 1'b1;
      n = 0;
      while (!ack && n < 20) begin
         @(negedge clk);
         n++;
      end
      check(n == 4, "R2 ack rise latency", n, 4);
      wide  = (longint'(exp_a) + 2) * 4 + 4;
      exp_a = DW'((exp_a + 16'sd2) * 16'sd4 + 16'sd4);
      if (wide != longint'(exp_a)) wraps++;
      exp_b = exp_b + 16'sd1;
      check(a_out == exp_a, "R5 a on ack edge", int'(a_out), int'(exp_a));
      check(b_out == exp_b, "R5 b on ack edge", int'(b_out), int'(exp_b));
      req = 1'b0;
      n = 0;
      while (ack && n < 20) begin
         @(negedge clk);
         n++;
      end
      check(n == 4, "R2 ack fall latency", n, 4);
      check(a_out == exp_a, "R3 R7 a after handshake", int'(a_out), int'(exp_a));
      check(b_out == exp_b, "R4 b after handshake", int'(b_out), int'(exp_b));
      for (int g = 0; g < gap; g++) begin
         @(negedge clk);
         check(!ack && a_out == exp_a && b_out == exp_b, "R6 idle hold",
               int'(a_out), int'(exp_a));
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      check(a_out == 16'sd1, "R1 reset a", int'(a_out), 1);
      check(b_out == 16'sd0, "R1 reset b", int'(b_out), 0);
      check(ack == 1'b0, "R1 reset ack", int'(ack), 0);
      rst = 1'b0;
      exp_a = 16'sd1;
      exp_b = 16'sd0;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         check(!ack && a_out == exp_a && b_out == exp_b, "R6 idle after reset",
               int'(a_out), int'(exp_a));
      end

      for (int h = 0; h < 24; h++) handshake(h % 4);
      check(wraps > 0, "R7 wrap exercised", wraps, 1);

      // R8: start a transaction, then reset in its middle
      @(negedge clk);
      req = 1'b1;
      repeat (2) @(negedge clk);
      req = 1'b0;
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      check(a_out == 16'sd1 && b_out == 16'sd0 && !ack, "R8 reset mid transaction",
            int'(a_out), 1);
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         check(!ack && a_out == 16'sd1 && b_out == 16'sd0, "R8 no stale ack",
               int'(ack), 0);
      end
      exp_a = 16'sd1;
      exp_b = 16'sd0;
      for (int h = 0; h < 6; h++) handshake(h);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule